// File: doc/BRIEF.md
# Karatsuba Two-Way Split Multiplier

This block multiplies two unsigned 34-bit operands and returns the exact 68-bit product. Each operand is cut into a 17-bit upper half and a 17-bit lower half. The block then uses three narrow signed multiplications instead of the four that a schoolbook split would need. The two lower halves are multiplied together, and so are the two upper halves. The third multiplication takes the difference of each operand's halves (upper minus lower, an 18-bit signed value) and multiplies the two differences. The cross term is then the sum of the two half products minus the product of the differences.

The narrow multiplications are generic registered 18x18 signed multiply-add cells joined by a cascade path. The first cell produces the low-half product. The second subtracts the difference product from it. The third adds the high-half product, so the last cell holds the cross term. The high-half product is recovered for the top of the result by subtracting the second cell's value from the third's. A final stage aligns the three terms: the lowest 17 result bits are taken straight from the low-half product, and everything above comes from a 17-bit-shifted accumulation.

Operands are accepted on every clock cycle with a valid strobe. The result appears with its own valid strobe exactly three cycles later.

Top module: `karat_mul34`

## Requirements
- R1: For any pair of unsigned operands presented with `in_valid` high, `out_prod` equals the exact unsigned 68-bit product `in_a * in_b`.
- R2: `out_valid` is high in exactly the cycle three clock edges after the edge that sampled `in_valid` high, and low otherwise. The result for that operand pair is on `out_prod` in the same cycle.
- R3: Operands may be presented on every consecutive cycle. Each one yields its own result, in order, one per cycle.
- R4: Bits 16:0 of `out_prod` equal bits 16:0 of the product of the two operands' lower 17-bit halves.
- R5: The cross-term accumulator never overflows. With both operands all ones (0x3FFFFFFFF) the result is 0xFFFFFFFF800000001, and the accumulated middle term always equals lowA*highB + highA*lowB.
- R6: The high-half product that is recovered by subtraction from the cascade equals highA*highB. Operands whose lower halves are zero give `out_prod` = (highA*highB) shifted left by 34.
- R7: The result is exact whatever the signs of the two half differences (upper half below, equal to or above the lower half), including differences of magnitude 0x1FFFF.
- R8: A synchronous active-high `rst` clears every valid stage on the clock edge where it is sampled. An operand accepted in the same cycle as reset, or still in flight when reset arrives, never raises `out_valid`. After reset `out_valid` reads 0.
- R9: Gaps in `in_valid` reappear as gaps in `out_valid` three cycles later, with no extra or missing results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Operand pair on `in_a`/`in_b` is to be multiplied |
| in_a | input | 34 | Unsigned multiplicand |
| in_b | input | 34 | Unsigned multiplier |
| out_valid | output | 1 | `out_prod` holds the result for an accepted pair |
| out_prod | output | 68 | Unsigned product |

## Verification
Two functions can land in the same cycle: a reset that clears the valid pipeline, and the acceptance of a new operand while earlier operands are still moving down the stages. The bench provokes this by streaming valid operands on consecutive cycles and raising reset in a cycle where `in_valid` is also high. It then judges that no result surfaces for any of those operands, and that the first operand after reset comes out normally three cycles later. The same overlap in its ordinary form, with a new operand entering as an older result leaves, is judged by streams with no gaps and by streams with random gaps. The behavioural model compares valid and product in every cycle.

// File: rtl/karat_pkg.sv
package karat_pkg;

  // Operand split geometry
  localparam int unsigned CHUNK = 17;            // width of one half
  localparam int unsigned OPW   = 2 * CHUNK;     // operand width
  localparam int unsigned PRODW = 2 * OPW;       // full product width
  localparam int unsigned DIFW  = CHUNK + 1;     // signed half difference
  localparam int unsigned NPW   = 2 * CHUNK;     // unsigned half product
  localparam int unsigned ACCW  = 2 * CHUNK + 4; // signed cascade accumulator
  localparam int unsigned UPW   = PRODW - CHUNK; // shifted upper accumulation

  // Pipeline geometry
  localparam int unsigned NCELL     = 3;  // multiply-add cells on the cascade
  localparam int unsigned DIFF_CELL = 1;  // the cell that subtracts
  localparam int unsigned LAT       = 3;  // presub + multiply + assemble

  typedef logic [CHUNK-1:0]        chunk_t;
  typedef logic signed [DIFW-1:0]  diff_t;
  typedef logic signed [ACCW-1:0]  acc_t;

  typedef struct packed {
    chunk_t a_hi;
    chunk_t a_lo;
    chunk_t b_hi;
    chunk_t b_lo;
    diff_t  a_dif;
    diff_t  b_dif;
  } split_t;

  // Upper half minus lower half, as a signed value one bit wider
  function automatic diff_t half_diff(input chunk_t hi, input chunk_t lo);
    diff_t hs;
    diff_t ls;
    hs = $signed({1'b0, hi});
    ls = $signed({1'b0, lo});
    return hs - ls;
  endfunction

  function automatic split_t split_operands(input logic [OPW-1:0] a,
                                            input logic [OPW-1:0] b);
    split_t s;
    s.a_lo  = a[CHUNK-1:0];
    s.a_hi  = a[OPW-1:CHUNK];
    s.b_lo  = b[CHUNK-1:0];
    s.b_hi  = b[OPW-1:CHUNK];
    s.a_dif = half_diff(s.a_hi, s.a_lo);
    s.b_dif = half_diff(s.b_hi, s.b_lo);
    return s;
  endfunction

  // Zero-extend an unsigned half into a signed multiplier operand
  function automatic diff_t widen_half(input chunk_t h);
    return $signed({1'b0, h});
  endfunction

  // High-half product recovered from two adjacent cascade taps
  function automatic acc_t recover_top(input acc_t chain_end, input acc_t chain_tap);
    return chain_end - chain_tap;
  endfunction

  // Bits below CHUNK come straight from the low product; the rest is the
  // low product's carry-out, the middle term and the top term shifted by CHUNK
  function automatic logic [PRODW-1:0] assemble(input acc_t low, input acc_t mid,
                                                input acc_t top);
    logic [UPW-1:0] up;
    up = UPW'(low[ACCW-1:CHUNK]) + UPW'(mid) + (UPW'(top) << CHUNK);
    return {up, low[CHUNK-1:0]};
  endfunction

endpackage

// File: rtl/karat_presub.sv
// Stage 1: split both operands into halves and register the half
// differences that feed the third multiplication.
module karat_presub
  import karat_pkg::*;
(
  input  logic           clk,
  input  logic [OPW-1:0] in_a,
  input  logic [OPW-1:0] in_b,
  output split_t         split_q
);

  split_t split_c;

  assign split_c = split_operands(in_a, in_b);

  // Data registers carry no reset (R8 applies to the valid path only)
  always_ff @(posedge clk) begin
    split_q <= split_c;
  end

endmodule

// File: rtl/karat_mac_cell.sv
// Generic registered signed multiply-add cell with a cascade input.
// The cascade may be arithmetically shifted before the add, and the
// product may be added or subtracted.
module karat_mac_cell #(
  parameter int unsigned OPA_W      = 18,
  parameter int unsigned OPB_W      = 18,
  parameter int unsigned ACC_W      = 38,
  parameter bit          SUBTRACT   = 1'b0,
  parameter int unsigned CASC_SHIFT = 0
) (
  input  logic                    clk,
  input  logic signed [OPA_W-1:0] op_a,
  input  logic signed [OPB_W-1:0] op_b,
  input  logic signed [ACC_W-1:0] casc_in,
  output logic signed [ACC_W-1:0] casc_out,
  output logic signed [ACC_W-1:0] acc_q
);

  localparam int unsigned PW = OPA_W + OPB_W;

  logic signed [PW-1:0]    prod;
  logic signed [ACC_W-1:0] prod_ext;
  logic signed [ACC_W-1:0] addend;

  assign prod     = op_a * op_b;
  assign prod_ext = ACC_W'(prod);

  generate
    if (CASC_SHIFT == 0) begin : g_casc_direct
      assign addend = casc_in;
    end else begin : g_casc_shifted
      assign addend = casc_in >>> CASC_SHIFT;
    end
  endgenerate

  generate
    if (SUBTRACT) begin : g_sub
      assign casc_out = addend - prod_ext;
    end else begin : g_add
      assign casc_out = addend + prod_ext;
    end
  endgenerate

  always_ff @(posedge clk) begin
    acc_q <= casc_out;
  end

endmodule

// File: rtl/karat_combine.sv
// Stage 3: recover the high-half product from the cascade taps and
// align the three terms into the full-width result.
module karat_combine
  import karat_pkg::*;
(
  input  logic             clk,
  input  acc_t             low_acc,   // lowA*lowB
  input  acc_t             diff_acc,  // lowA*lowB - difA*difB
  input  acc_t             mid_acc,   // cross term
  output acc_t             mid_sum,
  output acc_t             top_rec,
  output logic [PRODW-1:0] prod_q
);

  assign mid_sum = mid_acc;
  assign top_rec = recover_top(mid_acc, diff_acc); // R6

  always_ff @(posedge clk) begin
    prod_q <= assemble(low_acc, mid_acc, top_rec);
  end

endmodule

// File: rtl/karat_mul34.sv
// Pipelined unsigned multiplier that uses three narrow multiplications
// on the cascade: lowA*lowB, then minus difA*difB, then plus highA*highB.
module karat_mul34
  import karat_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [OPW-1:0]   in_a,
  input  logic [OPW-1:0]   in_b,
  output logic             out_valid,
  output logic [PRODW-1:0] out_prod
);

  // Stage 1: split and pre-subtract
  split_t split_q;

  karat_presub u_presub (
    .clk     (clk),
    .in_a    (in_a),
    .in_b    (in_b),
    .split_q (split_q)
  );

  // Stage 2: three multiply-add cells on one cascade
  diff_t cell_a  [NCELL];
  diff_t cell_b  [NCELL];
  acc_t  casc    [NCELL+1];
  acc_t  cell_q  [NCELL];

  assign cell_a[0] = widen_half(split_q.a_lo);
  assign cell_b[0] = widen_half(split_q.b_lo);
  assign cell_a[1] = split_q.a_dif;
  assign cell_b[1] = split_q.b_dif;
  assign cell_a[2] = widen_half(split_q.a_hi);
  assign cell_b[2] = widen_half(split_q.b_hi);
  assign casc[0]   = '0;

  generate
    for (genvar i = 0; i < NCELL; i++) begin : g_cell
      karat_mac_cell #(
        .OPA_W      (DIFW),
        .OPB_W      (DIFW),
        .ACC_W      (ACCW),
        .SUBTRACT   (i == DIFF_CELL),
        .CASC_SHIFT (0)
      ) u_cell (
        .clk      (clk),
        .op_a     (cell_a[i]),
        .op_b     (cell_b[i]),
        .casc_in  (casc[i]),
        .casc_out (casc[i+1]),
        .acc_q    (cell_q[i])
      );
    end
  endgenerate

  // Stage 3: recovery and alignment
  acc_t mid_sum;
  acc_t top_rec;

  karat_combine u_combine (
    .clk      (clk),
    .low_acc  (cell_q[0]),
    .diff_acc (cell_q[DIFF_CELL]),
    .mid_acc  (cell_q[NCELL-1]),
    .mid_sum  (mid_sum),
    .top_rec  (top_rec),
    .prod_q   (out_prod)
  );

  // Valid path: one flag per data stage, cleared by reset (R2, R8)
  logic [LAT-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else begin
      vld_q <= {vld_q[LAT-2:0], in_valid};
    end
  end

  assign out_valid = vld_q[LAT-1];

endmodule

// File: rtl/karat_mul34_chk.sv
module karat_mul34_chk
  import karat_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [OPW-1:0]   in_a,
  input logic [OPW-1:0]   in_b,
  input logic             out_valid,
  input logic [PRODW-1:0] out_prod,
  input acc_t             mid_sum,
  input acc_t             top_rec
);

  // Edges since reset release, saturating at LAT
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)               age <= '0;
    else if (age != 2'd3)  age <= age + 2'd1;
  end

  logic [PRODW-1:0] full_ref;
  logic [CHUNK-1:0] low_ref;
  logic [NPW-1:0]   hi_ref;
  logic [ACCW-1:0]  cross_ref;

  assign full_ref  = PRODW'(in_a) * PRODW'(in_b);
  assign low_ref   = CHUNK'(NPW'(in_a[CHUNK-1:0]) * NPW'(in_b[CHUNK-1:0]));
  assign hi_ref    = NPW'(in_a[OPW-1:CHUNK]) * NPW'(in_b[OPW-1:CHUNK]);
  assign cross_ref = ACCW'(in_a[CHUNK-1:0]) * ACCW'(in_b[OPW-1:CHUNK])
                   + ACCW'(in_a[OPW-1:CHUNK]) * ACCW'(in_b[CHUNK-1:0]);

  AST_PRODUCT: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && out_valid) |-> out_prod == $past(full_ref, 3)); // R1

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) |-> out_valid == $past(in_valid, 3)); // R2

  AST_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) |-> out_prod[CHUNK-1:0] == $past(low_ref, 3)); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2) |-> $unsigned(mid_sum) == $past(cross_ref, 2)); // R5

  AST_TOP_RECOVER: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2) |-> $unsigned(top_rec) == ACCW'($past(hi_ref, 2))); // R6

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> !out_valid); // R8

endmodule

bind karat_mul34 karat_mul34_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_a      (in_a),
  .in_b      (in_b),
  .out_valid (out_valid),
  .out_prod  (out_prod),
  .mid_sum   (mid_sum),
  .top_rec   (top_rec)
);

// File: tb/sim_karat_mul34.sv
`timescale 1ns/1ps
module sim_karat_mul34;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [33:0] in_a = '0;
  logic [33:0] in_b = '0;
  logic        out_valid;
  logic [67:0] out_prod;

  int    checks = 0;
  int    errors = 0;
  string cur_tag = "R1";
  bit    cmp_en = 1'b0;

  localparam logic [67:0] ONES_SQ = 68'hFFFFFFFF800000001;

  always #10 clk = ~clk;

  karat_mul34 u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_prod(out_prod)
  );

  function automatic logic [67:0] ref_mul(input logic [33:0] a, input logic [33:0] b);
    return 68'(a) * 68'(b);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [67:0] act,
                     input logic [67:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Behavioural model: per-edge history of (accepted, product)
  bit          qv[$];
  logic [67:0] qp[$];
  bit          exp_v = 1'b0;
  logic [67:0] exp_p = '0;
  bit          have = 1'b0;

  always @(posedge clk) begin
    if (rst) foreach (qv[i]) qv[i] = 1'b0;
    qv.push_back(in_valid && !rst);
    qp.push_back(ref_mul(in_a, in_b));
    if (qv.size() > 3) begin
      qv = qv[1:$];
      qp = qp[1:$];
    end
    have  = (qv.size() == 3);
    exp_v = qv[0];
    exp_p = qp[0];
  end

  always @(negedge clk) begin
    if (have && cmp_en) begin
      chk(out_valid === exp_v, "R2", 68'(out_valid), 68'(exp_v));
      if (exp_v) begin
        chk(out_prod === exp_p, cur_tag, out_prod, exp_p);
        chk(out_prod[16:0] === exp_p[16:0], "R4", 68'(out_prod[16:0]), 68'(exp_p[16:0]));
      end
    end
  end

  task automatic drive(input bit v, input logic [33:0] a, input logic [33:0] b);
    @(negedge clk);
    in_valid = v;
    in_a = a;
    in_b = b;
  endtask

  function automatic logic [33:0] rnd34();
    return 34'({$urandom(), $urandom()});
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    int seen;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0, "R8", 68'(out_valid), 68'd0);   // reset state
    cmp_en = 1'b1;

    // R2: single operand, count cycles to the result
    cur_tag = "R2";
    drive(1, 34'h2_0001_0003, 34'h1_FFFF_0005);
    drive(0, '0, '0);
    n = 1;
    while (!out_valid && n < 10) begin
      @(negedge clk);
      n++;
    end
    chk(n == 3, "R2", 68'(n), 68'd3);
    @(negedge clk);
    chk(out_valid === 1'b0, "R2", 68'(out_valid), 68'd0);

    // R5: all ones on both operands
    cur_tag = "R5";
    drive(1, 34'h3_FFFF_FFFF, 34'h3_FFFF_FFFF);
    drive(0, '0, '0);
    @(negedge clk);
    @(negedge clk);
    chk(out_prod === ONES_SQ, "R5", out_prod, ONES_SQ);
    drive(1, 34'h3_FFFF_FFFF, 34'h1);
    drive(1, 34'h3_FFFF_FFFF, 34'h0);
    drive(1, 34'h3_FFFF_FFFF, 34'h3_FFFF_FFFF);
    drive(0, '0, '0);
    repeat (4) @(negedge clk);

    // R6: lower halves zero, result is the shifted high product
    cur_tag = "R6";
    drive(1, 34'h3_FFFE_0000, 34'h3_FFFE_0000);
    drive(0, '0, '0);
    @(negedge clk);
    @(negedge clk);
    chk(out_prod === (68'(17'h1FFFF) * 68'(17'h1FFFF)) << 34, "R6",
        out_prod, (68'(17'h1FFFF) * 68'(17'h1FFFF)) << 34);
    for (int i = 0; i < 8; i++) drive(1, {rnd34()} & 34'h3_FFFE_0000, {rnd34()} & 34'h3_FFFE_0000);
    drive(0, '0, '0);
    repeat (4) @(negedge clk);

    // R7: every sign combination of the half differences
    cur_tag = "R7";
    drive(1, {17'd0, 17'h1FFFF}, {17'h1FFFF, 17'd0});     // -max * +max
    drive(1, {17'd0, 17'h1FFFF}, {17'd0, 17'h1FFFF});     // -max * -max
    drive(1, {17'h1FFFF, 17'd0}, {17'h1FFFF, 17'd0});     // +max * +max
    drive(1, {17'h00123, 17'h00123}, {17'h1F000, 17'h00001}); // zero * +
    drive(1, {17'h00010, 17'h1F000}, {17'h00001, 17'h1F000}); // - * -
    for (int i = 0; i < 16; i++) drive(1, rnd34(), rnd34());
    drive(0, '0, '0);
    repeat (4) @(negedge clk);

    // R3: back-to-back random stream
    cur_tag = "R3";
    for (int i = 0; i < 300; i++) drive(1, rnd34(), rnd34());

    // R1: corner operands mixed with random ones
    cur_tag = "R1";
    drive(1, 34'h0, 34'h3_FFFF_FFFF);
    drive(1, 34'h0_0002_0000, 34'h0_0001_FFFF);
    drive(1, 34'h2_0000_0000, 34'h2_0000_0000);
    drive(1, 34'h1_FFFF_FFFF, 34'h3_0000_0001);
    for (int i = 0; i < 100; i++) drive(1, rnd34(), rnd34());

    // R9: random gaps in the valid stream
    cur_tag = "R9";
    for (int i = 0; i < 200; i++) drive(bit'($urandom() & 1), rnd34(), rnd34());
    drive(0, '0, '0);
    repeat (4) @(negedge clk);

    // R8: reset in the same cycle as a new operand, with others in flight
    cur_tag = "R8";
    drive(1, rnd34(), rnd34());
    drive(1, rnd34(), rnd34());
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b1;
    in_a = rnd34();
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;
    seen = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (out_valid) seen++;
    end
    chk(seen == 0, "R8", 68'(seen), 68'd0);
    drive(1, 34'h3_FFFF_FFFF, 34'h3_FFFF_FFFF);
    drive(0, '0, '0);
    @(negedge clk);
    @(negedge clk);
    chk(out_valid === 1'b1 && out_prod === ONES_SQ, "R8", out_prod, ONES_SQ);

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule